// File: doc/BRIEF.md
# BCD Date/Time Entry Validator

This block sits in front of the time and calendar registers of a real-time clock. It checks a proposed write before anything is committed. The write carries eight packed BCD fields: century, year, month, date, day-of-week, hour, minute and second. It also carries a 12/24-hour mode bit, an AM/PM bit and a select for an alternate calendar.

Every field is judged on every cycle, and the results appear on a combinational valid mask. When `wrEn` is pulsed and every field passes, the fields are registered and `commitPulse` is high for the next cycle. In 12-hour mode the hour is stored in its 24-hour form. A write that fails any check changes nothing that is stored. It sets a flag that stays set until reset.

The block does not advance the counters, and it has no bus interface beyond the write strobe and the data inputs.

Top module: `bcd_entry_validator`

## Requirements
- R1: Century (mask bit 7) is valid for BCD 19 to 20 when `altCal` is 0, and for 13 to 14 when `altCal` is 1.
- R2: Year (mask bit 6) is valid for any value whose two nibbles are both BCD digits.
- R3: Month (mask bit 5) is valid for 01 to 12.
- R4: Date (mask bit 4) is valid from 01 up to a limit set by the month. The limit is 29 for month 02, 30 for months 04, 06, 09 and 11, and 31 for every other month value.
- R5: Day-of-week (mask bit 3, a 4-bit field) is valid for 1 to 7.
- R6: With `mode12`=0, hour (mask bit 2) is valid for 00 to 23, and only while `pmIn` is 0.
- R7: With `mode12`=1, hour (mask bit 2) is valid for 01 to 12, whatever the value of `pmIn`.
- R8: Minute (mask bit 1) and second (mask bit 0) are each valid for 00 to 59.
- R9: A field with any nibble above 9 is invalid, even if its numeric value would pass the range check.
- R10: `entryOk` is the AND of all mask bits. A write with `entryOk`=1 stores every field, and the stored values appear on the outputs on the cycle after the `wrEn` edge. On that same cycle `commitPulse` is high, for that cycle only.
- R11: In 12-hour mode the stored hour is the 24-hour BCD value. 12 AM stores 00 and 12 PM stores 12. Any other PM hour stores the hour plus 12, and any other AM hour stores the hour unchanged. In 24-hour mode the hour is stored as written.
- R12: A write with `entryOk`=0 leaves every stored output unchanged and gives no `commitPulse`. It sets `badEntry`, which stays at 1 until reset. Inputs presented without `wrEn` affect neither the stored outputs nor `badEntry`.
- R13: After reset the stored outputs are century 20, year 00, month 01, date 01, day 1, hour 00, minute 00 and second 00, and both `commitPulse` and `badEntry` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the presented fields |
| centuryIn | input | 8 | Century, BCD |
| yearIn | input | 8 | Year, BCD |
| monthIn | input | 8 | Month, BCD |
| dateIn | input | 8 | Date of month, BCD |
| dayIn | input | 4 | Day of week, BCD |
| hourIn | input | 8 | Hour, BCD |
| minIn | input | 8 | Minute, BCD |
| secIn | input | 8 | Second, BCD |
| mode12 | input | 1 | 1 = 12-hour entry |
| pmIn | input | 1 | PM indicator |
| altCal | input | 1 | Alternate calendar century range |
| fieldOk | output | 8 | Per-field valid mask (bit 7 century down to bit 0 second) |
| entryOk | output | 1 | All fields valid |
| commitPulse | output | 1 | One-cycle pulse after an accepted write |
| badEntry | output | 1 | Sticky rejected-write flag |
| centuryQ | output | 8 | Stored century |
| yearQ | output | 8 | Stored year |
| monthQ | output | 8 | Stored month |
| dateQ | output | 8 | Stored date |
| dayQ | output | 4 | Stored day of week |
| hourQ | output | 8 | Stored hour, 24-hour BCD |
| minQ | output | 8 | Stored minute |
| secQ | output | 8 | Stored second |

## Verification
The assertions take for granted that reset is applied before the first write. They also assume that the data inputs are stable around each clock edge, so that the mask seen at the edge with `wrEn` high is the one that decides the write. The bench drives each field set and `wrEn` on the falling edge and holds them through the next rising edge. It reads the mask halfway through that window and the registered results on the following falling edge. Every write vector holds the inputs steady for a full cycle, so the stored-hour property sees only values that passed the hour check.

// File: rtl/dtv_pkg.sv
package dtv_pkg;
  localparam int NFIELD = 8;
  localparam int BW     = 8;
  localparam int DW     = 4;

  // mask bit positions
  localparam int F_SEC = 0;
  localparam int F_MIN = 1;
  localparam int F_HR  = 2;
  localparam int F_DAY = 3;
  localparam int F_DAT = 4;
  localparam int F_MON = 5;
  localparam int F_YR  = 6;
  localparam int F_CEN = 7;

  typedef struct packed {
    logic loadEn;
    logic markBad;
  } dtv_strobe_t;

  function automatic logic digitsOk(input logic [BW-1:0] v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  function automatic logic [BW-1:0] bcdToBin(input logic [BW-1:0] v);
    return BW'(v[7:4]) * BW'(10) + BW'(v[3:0]);
  endfunction

  function automatic logic [BW-1:0] binToBcd(input logic [BW-1:0] b);
    logic [BW-1:0] tens, ones;
    tens = b / BW'(10);
    ones = b % BW'(10);
    return {tens[3:0], ones[3:0]};
  endfunction
endpackage

// File: rtl/dtv_datapath.sv
module dtv_datapath
  import dtv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dtv_strobe_t       strobe,
  input  logic [BW-1:0]     centuryIn,
  input  logic [BW-1:0]     yearIn,
  input  logic [BW-1:0]     monthIn,
  input  logic [BW-1:0]     dateIn,
  input  logic [DW-1:0]     dayIn,
  input  logic [BW-1:0]     hourIn,
  input  logic [BW-1:0]     minIn,
  input  logic [BW-1:0]     secIn,
  input  logic              mode12,
  input  logic              pmIn,
  input  logic              altCal,
  output logic [NFIELD-1:0] fieldOk,
  output logic              allOk,
  output logic [BW-1:0]     centuryQ,
  output logic [BW-1:0]     yearQ,
  output logic [BW-1:0]     monthQ,
  output logic [BW-1:0]     dateQ,
  output logic [DW-1:0]     dayQ,
  output logic [BW-1:0]     hourQ,
  output logic [BW-1:0]     minQ,
  output logic [BW-1:0]     secQ
);
  logic [BW-1:0] cenLo, cenHi, dateLimit, hourBin, hourStoreBin, hourStore;
  logic [BW-1:0] msIn [2];
  logic          msOk [2];

  assign msIn[0] = secIn;
  assign msIn[1] = minIn;

  // minute and second share one range rule
  for (genvar g = 0; g < 2; g++) begin : g_ms
    assign msOk[g] = digitsOk(msIn[g]) && (bcdToBin(msIn[g]) <= BW'(59));
  end

  always_comb begin
    cenLo = altCal ? BW'(13) : BW'(19);
    cenHi = altCal ? BW'(14) : BW'(20);
    unique case (monthIn)
      8'h02:                      dateLimit = BW'(29);
      8'h04, 8'h06, 8'h09, 8'h11: dateLimit = BW'(30);
      default:                    dateLimit = BW'(31);
    endcase
    hourBin = bcdToBin(hourIn);

    fieldOk        = '0;
    fieldOk[F_SEC] = msOk[0];
    fieldOk[F_MIN] = msOk[1];
    fieldOk[F_CEN] = digitsOk(centuryIn) && (bcdToBin(centuryIn) >= cenLo)
                     && (bcdToBin(centuryIn) <= cenHi);
    fieldOk[F_YR]  = digitsOk(yearIn);
    fieldOk[F_MON] = digitsOk(monthIn) && (monthIn >= 8'h01) && (monthIn <= 8'h12);
    fieldOk[F_DAT] = digitsOk(dateIn) && (dateIn != 8'h00)
                     && (bcdToBin(dateIn) <= dateLimit);
    fieldOk[F_DAY] = (dayIn >= 4'd1) && (dayIn <= 4'd7);
    if (mode12)
      fieldOk[F_HR] = digitsOk(hourIn) && (hourBin >= BW'(1)) && (hourBin <= BW'(12));
    else
      fieldOk[F_HR] = digitsOk(hourIn) && (hourBin <= BW'(23)) && !pmIn;

    // 12-hour to 24-hour conversion
    if (!mode12)             hourStoreBin = hourBin;
    else if (hourBin == BW'(12)) hourStoreBin = pmIn ? BW'(12) : BW'(0);
    else                     hourStoreBin = pmIn ? hourBin + BW'(12) : hourBin;
    hourStore = binToBcd(hourStoreBin);
  end

  assign allOk = &fieldOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      centuryQ <= 8'h20;
      yearQ    <= 8'h00;
      monthQ   <= 8'h01;
      dateQ    <= 8'h01;
      dayQ     <= 4'h1;
      hourQ    <= 8'h00;
      minQ     <= 8'h00;
      secQ     <= 8'h00;
    end else if (strobe.loadEn) begin
      centuryQ <= centuryIn;
      yearQ    <= yearIn;
      monthQ   <= monthIn;
      dateQ    <= dateIn;
      dayQ     <= dayIn;
      hourQ    <= hourStore;
      minQ     <= minIn;
      secQ     <= secIn;
    end
  end

  p_stored_stable_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> $stable({centuryQ, yearQ, monthQ, dateQ, dayQ, hourQ, minQ, secQ}));

  p_hour24_legal_r11: assert property (@(posedge clk) disable iff (!rstN)
    digitsOk(hourQ) && (hourQ <= 8'h23));

  p_pm_in24_rejected_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!mode12 && pmIn) |-> !fieldOk[F_HR]);

  p_load_only_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |-> allOk);
endmodule

// File: rtl/dtv_control.sv
module dtv_control
  import dtv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        allOk,
  output dtv_strobe_t strobe,
  output logic        commitPulse,
  output logic        badEntry
);
  always_comb begin
    strobe.loadEn  = wrEn && allOk;
    strobe.markBad = wrEn && !allOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitPulse <= 1'b0;
      badEntry    <= 1'b0;
    end else begin
      commitPulse <= strobe.loadEn;
      if (strobe.markBad) badEntry <= 1'b1;
    end
  end

  p_commit_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(wrEn && allOk));

  p_no_commit_on_reject_r12: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !allOk) |=> (!commitPulse && badEntry));

  p_bad_sticky_r12: assert property (@(posedge clk) disable iff (!rstN)
    badEntry |=> badEntry);
endmodule

// File: rtl/bcd_entry_validator.sv
module bcd_entry_validator
  import dtv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [BW-1:0]     centuryIn,
  input  logic [BW-1:0]     yearIn,
  input  logic [BW-1:0]     monthIn,
  input  logic [BW-1:0]     dateIn,
  input  logic [DW-1:0]     dayIn,
  input  logic [BW-1:0]     hourIn,
  input  logic [BW-1:0]     minIn,
  input  logic [BW-1:0]     secIn,
  input  logic              mode12,
  input  logic              pmIn,
  input  logic              altCal,
  output logic [NFIELD-1:0] fieldOk,
  output logic              entryOk,
  output logic              commitPulse,
  output logic              badEntry,
  output logic [BW-1:0]     centuryQ,
  output logic [BW-1:0]     yearQ,
  output logic [BW-1:0]     monthQ,
  output logic [BW-1:0]     dateQ,
  output logic [DW-1:0]     dayQ,
  output logic [BW-1:0]     hourQ,
  output logic [BW-1:0]     minQ,
  output logic [BW-1:0]     secQ
);
  dtv_strobe_t strobe;
  logic        allOk;

  dtv_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .centuryIn(centuryIn), .yearIn(yearIn), .monthIn(monthIn), .dateIn(dateIn),
    .dayIn(dayIn), .hourIn(hourIn), .minIn(minIn), .secIn(secIn),
    .mode12(mode12), .pmIn(pmIn), .altCal(altCal),
    .fieldOk(fieldOk), .allOk(allOk),
    .centuryQ(centuryQ), .yearQ(yearQ), .monthQ(monthQ), .dateQ(dateQ),
    .dayQ(dayQ), .hourQ(hourQ), .minQ(minQ), .secQ(secQ)
  );

  dtv_control u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .allOk(allOk),
    .strobe(strobe), .commitPulse(commitPulse), .badEntry(badEntry)
  );

  assign entryOk = allOk;
endmodule

// File: tb/bcd_entry_validator_bench.sv
module bcd_entry_validator_bench;
  typedef struct packed {
    logic [7:0] cen, yr, mon, dat;
    logic [3:0] day;
    logic [7:0] hr, mn, sc;
    logic       m12, pm, alt;
    logic [7:0] mask;
    logic [7:0] hrExp;
  } vec_t;

  localparam int NV = 24;
  // fields: cen yr mon dat day hr mn sc m12 pm alt | mask hourStored
  localparam vec_t TBL [NV] = '{
    '{8'h20,8'h24,8'h03,8'h15,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hFF,8'h13}, // R10 base
    '{8'h14,8'h24,8'h03,8'h15,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b1, 8'hFF,8'h13}, // R1 alt ok
    '{8'h20,8'h24,8'h03,8'h15,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b1, 8'h7F,8'h00}, // R1 alt 20
    '{8'h18,8'h24,8'h03,8'h15,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'h7F,8'h00}, // R1 18
    '{8'h20,8'h2A,8'h03,8'h15,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hBF,8'h00}, // R2 R9
    '{8'h20,8'h24,8'h13,8'h15,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hDF,8'h00}, // R3 13
    '{8'h20,8'h24,8'h00,8'h15,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hDF,8'h00}, // R3 00
    '{8'h20,8'h24,8'h04,8'h31,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hEF,8'h00}, // R4 apr 31
    '{8'h20,8'h24,8'h02,8'h29,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hFF,8'h13}, // R4 feb 29
    '{8'h20,8'h24,8'h02,8'h30,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hEF,8'h00}, // R4 feb 30
    '{8'h20,8'h24,8'h12,8'h00,4'h3,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hEF,8'h00}, // R4 date 00
    '{8'h20,8'h24,8'h12,8'h31,4'h0,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hF7,8'h00}, // R5 day 0
    '{8'h20,8'h24,8'h12,8'h31,4'h8,8'h13,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hF7,8'h00}, // R5 day 8
    '{8'h20,8'h24,8'h12,8'h31,4'h7,8'h24,8'h45,8'h30,1'b0,1'b0,1'b0, 8'hFB,8'h00}, // R6 hr 24
    '{8'h20,8'h24,8'h12,8'h31,4'h7,8'h23,8'h45,8'h30,1'b0,1'b1,1'b0, 8'hFB,8'h00}, // R6 pm in 24h
    '{8'h20,8'h24,8'h12,8'h31,4'h7,8'h00,8'h45,8'h30,1'b1,1'b0,1'b0, 8'hFB,8'h00}, // R7 12h 00
    '{8'h20,8'h24,8'h12,8'h31,4'h7,8'h13,8'h45,8'h30,1'b1,1'b1,1'b0, 8'hFB,8'h00}, // R7 12h 13
    '{8'h20,8'h24,8'h12,8'h31,4'h7,8'h12,8'h45,8'h30,1'b1,1'b0,1'b0, 8'hFF,8'h00}, // R11 12AM
    '{8'h20,8'h24,8'h12,8'h31,4'h7,8'h12,8'h45,8'h30,1'b1,1'b1,1'b0, 8'hFF,8'h12}, // R11 12PM
    '{8'h20,8'h24,8'h12,8'h31,4'h7,8'h07,8'h45,8'h30,1'b1,1'b1,1'b0, 8'hFF,8'h19}, // R11 7PM
    '{8'h20,8'h24,8'h12,8'h31,4'h7,8'h11,8'h45,8'h30,1'b1,1'b0,1'b0, 8'hFF,8'h11}, // R11 11AM
    '{8'h20,8'h24,8'h12,8'h31,4'h7,8'h09,8'h60,8'h30,1'b0,1'b0,1'b0, 8'hFD,8'h00}, // R8 min 60
    '{8'h20,8'h24,8'h12,8'h31,4'h7,8'h09,8'h59,8'h5A,1'b0,1'b0,1'b0, 8'hFE,8'h00}, // R8 R9 sec
    '{8'h19,8'h99,8'h11,8'h30,4'h1,8'h23,8'h59,8'h59,1'b0,1'b0,1'b0, 8'hFF,8'h23}  // R8 R10 max
  };

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [7:0] centuryIn, yearIn, monthIn, dateIn, hourIn, minIn, secIn;
  logic [3:0] dayIn;
  logic mode12, pmIn, altCal;
  logic [7:0] fieldOk, centuryQ, yearQ, monthQ, dateQ, hourQ, minQ, secQ;
  logic [3:0] dayQ;
  logic entryOk, commitPulse, badEntry;

  int total = 0, bad = 0;
  logic [59:0] model;   // expected stored fields
  bit expBad = 1'b0;

  always #5 clk = ~clk;

  bcd_entry_validator u_bcd_entry_validator (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .centuryIn(centuryIn), .yearIn(yearIn), .monthIn(monthIn), .dateIn(dateIn),
    .dayIn(dayIn), .hourIn(hourIn), .minIn(minIn), .secIn(secIn),
    .mode12(mode12), .pmIn(pmIn), .altCal(altCal),
    .fieldOk(fieldOk), .entryOk(entryOk), .commitPulse(commitPulse), .badEntry(badEntry),
    .centuryQ(centuryQ), .yearQ(yearQ), .monthQ(monthQ), .dateQ(dateQ),
    .dayQ(dayQ), .hourQ(hourQ), .minQ(minQ), .secQ(secQ)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input bit we);
    @(negedge clk);
    centuryIn = v.cen; yearIn = v.yr; monthIn = v.mon; dateIn = v.dat; dayIn = v.day;
    hourIn = v.hr; minIn = v.mn; secIn = v.sc; mode12 = v.m12; pmIn = v.pm; altCal = v.alt;
    wrEn = we;
  endtask

  function automatic logic [59:0] storedNow();
    return {centuryQ, yearQ, monthQ, dateQ, dayQ, hourQ, minQ, secQ};
  endfunction

  task automatic checkAfterEdge(input string req, input bit expCommit);
    @(negedge clk);
    wrEn = 1'b0;
    chk(commitPulse == expCommit, {req, " commit"}, 64'(commitPulse), 64'(expCommit));
    chk(badEntry == expBad, {req, " badEntry"}, 64'(badEntry), 64'(expBad));
    chk(storedNow() == model, {req, " stored"}, 64'(storedNow()), 64'(model));
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    drive(TBL[0], 1'b0);
    repeat (2) @(negedge clk);
    model = {8'h20, 8'h00, 8'h01, 8'h01, 4'h1, 8'h00, 8'h00, 8'h00};
    // R13: reset state
    chk(storedNow() == model, "R13 reset fields", 64'(storedNow()), 64'(model));
    chk(!commitPulse && !badEntry, "R13 reset flags", {62'd0, commitPulse, badEntry}, 64'd0);
    rstN = 1'b1;

    // R12: invalid inputs without wrEn touch nothing
    drive(TBL[3], 1'b0);
    checkAfterEdge("R12 idle invalid", 1'b0);
    drive(TBL[0], 1'b0);
    checkAfterEdge("R12 idle valid", 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i], 1'b1);
      #2;
      chk(fieldOk == TBL[i].mask, $sformatf("R1-9 mask vec %0d (R9)", i), 64'(fieldOk), 64'(TBL[i].mask));
      chk(entryOk == (TBL[i].mask == 8'hFF), $sformatf("R10 entryOk vec %0d", i),
          64'(entryOk), 64'(TBL[i].mask == 8'hFF));
      if (TBL[i].mask == 8'hFF)
        model = {TBL[i].cen, TBL[i].yr, TBL[i].mon, TBL[i].dat, TBL[i].day,
                 TBL[i].hrExp, TBL[i].mn, TBL[i].sc};
      else
        expBad = 1'b1;
      checkAfterEdge($sformatf("R10 R11 R12 write vec %0d", i), TBL[i].mask == 8'hFF);
      // R10: pulse lasts one cycle only
      @(negedge clk);
      chk(commitPulse == 1'b0, "R10 pulse width", 64'(commitPulse), 64'd0);
    end

    // R10: back-to-back accepted writes pulse on both cycles
    drive(TBL[19], 1'b1);
    @(negedge clk);
    chk(commitPulse == 1'b1, "R10 back-to-back first", 64'(commitPulse), 64'd1);
    centuryIn = 8'h20; hourIn = 8'h05; pmIn = 1'b0;
    model = {8'h20, TBL[19].yr, TBL[19].mon, TBL[19].dat, TBL[19].day, 8'h05, TBL[19].mn, TBL[19].sc};
    checkAfterEdge("R10 R11 back-to-back second", 1'b1);

    // R12: flag stays set across a later accepted write and idle cycles
    repeat (3) @(negedge clk);
    chk(badEntry == 1'b1, "R12 sticky", 64'(badEntry), 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule